// File: doc/BRIEF.md
# Microprogram Sequencer with Flag-Driven Branching

This block steps through a microprogram held in an internal control store and hands the datapath its control word, one microinstruction per microcycle. Every microcycle takes four clock edges. A two-bit sub-cycle counter marks them. On the first edge the microinstruction register is loaded from the store at the current microprogram address. The next two edges give the buses and the ALU/shifter time to work while the control word is held. On the fourth edge the next address is chosen.

Each stored word has three fields: a datapath control field, a two-bit condition code and a target address. On the deciding edge, the condition code selects between the address plus one and the target. The choice can be fixed or can follow the negative (N) or zero (Z) flag that the ALU reports. The store is written through a simple synchronous write port, normally while the sequencer is held in reset.

Top module: `useq_ctrl`

## Requirements
- R1: A stored word places the control field in bits [CTRL_W-1:0], the condition code in bits [CTRL_W+1:CTRL_W] and the target address in the topmost ADDR_W bits.
- R2: While `rst` is high at a rising edge, the microprogram address, the sub-cycle number and `ctrl_out` are all cleared to zero.
- R3: The sub-cycle number `phase` advances 0, 1, 2, 3 and then returns to 0, one step per clock edge.
- R4: Condition code 0 never branches: the next address is the current address plus one, whatever the flags are.
- R5: Condition code 1 branches to the target when `flag_n` is 1 on the deciding edge, and otherwise goes to the address plus one.
- R6: Condition code 2 branches to the target when `flag_z` is 1 on the deciding edge, and otherwise goes to the address plus one.
- R7: Condition code 3 always branches to the target.
- R8: Sequential stepping from the highest address wraps around to address 0.
- R9: `ctrl_out` takes the control field of the word at the current address on the edge that leaves phase 0, and holds that value through phases 1, 2 and 3.
- R10: The flags are used only on the edge that leaves phase 3. Their values during phases 0 to 2 have no effect.
- R11: `upc` changes only on the edge that leaves phase 3.
- R12: A rising edge with `wr_en` high stores `wr_data` at `wr_addr`. A later fetch from that address returns the stored word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Control store write strobe |
| wr_addr | input | ADDR_W | Control store write address |
| wr_data | input | CTRL_W+2+ADDR_W | Word to store |
| flag_n | input | 1 | ALU negative flag |
| flag_z | input | 1 | ALU zero flag |
| ctrl_out | output | CTRL_W | Datapath control field of the current microinstruction |
| upc | output | ADDR_W | Microprogram address |
| phase | output | 2 | Sub-cycle number within the microcycle |

## Verification
The bench uses the default configuration: an 8-bit address and a 22-bit control field. It fills all 256 store words with contents computed from their address, so every condition code appears under every combination of flags. A model in the bench follows the address trace for several hundred microcycles. In phases 0 to 2 it drives the opposite flag values, so that sampling the flags at the wrong time would change the trace. A second, short program steps through address 255 to show the wraparound.

// File: rtl/useq_ctrl.sv
module useq_ctrl #(
  parameter int ADDR_W = 8,
  parameter int CTRL_W = 22
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [CTRL_W+2+ADDR_W-1:0] wr_data,
  input  logic                       flag_n,
  input  logic                       flag_z,
  output logic [CTRL_W-1:0]          ctrl_out,
  output logic [ADDR_W-1:0]          upc,
  output logic [1:0]                 phase
);

  localparam int WORD_W = CTRL_W + 2 + ADDR_W;
  localparam int DEPTH  = 1 << ADDR_W;

  logic [WORD_W-1:0] store [DEPTH];
  logic [WORD_W-1:0] mir;
  logic [ADDR_W-1:0] pc;
  logic [1:0]        ph;
  logic              take;

  wire [1:0]        cond = mir[CTRL_W +: 2];
  wire [ADDR_W-1:0] tgt  = mir[CTRL_W+2 +: ADDR_W];
  wire [ADDR_W-1:0] seq  = pc + 1'b1;

  always_ff @(posedge clk)
    if (wr_en) store[wr_addr] <= wr_data;

  always_comb
    case (cond)
      2'd0:    take = 1'b0;
      2'd1:    take = flag_n;
      2'd2:    take = flag_z;
      default: take = 1'b1;
    endcase

  always_ff @(posedge clk)
    if (rst) begin
      ph  <= '0;
      pc  <= '0;
      mir <= '0;
    end else begin
      ph <= ph + 1'b1;
      if (ph == 2'd0) mir <= store[pc];
      if (ph == 2'd3) pc  <= take ? tgt : seq;
    end

  assign ctrl_out = mir[CTRL_W-1:0];
  assign upc      = pc;
  assign phase    = ph;

  p_phase_wrap_r3: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3) |=> (ph == 2'd0));
  p_phase_step_r3: assert property (@(posedge clk) disable iff (rst)
    (ph != 2'd3) |=> (ph == $past(ph) + 2'd1));
  p_upc_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (ph != 2'd3) |=> $stable(upc));
  p_ctrl_stable_r9: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd1 || ph == 2'd2) |=> $stable(ctrl_out));
  p_never_r4: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && cond == 2'd0) |=> (upc == $past(upc) + 1'b1));
  p_on_n_r5: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && cond == 2'd1) |=>
      (upc == ($past(flag_n) ? $past(tgt) : $past(upc) + 1'b1)));
  p_on_z_r6: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && cond == 2'd2) |=>
      (upc == ($past(flag_z) ? $past(tgt) : $past(upc) + 1'b1)));
  p_always_r7: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && cond == 2'd3) |=> (upc == $past(tgt)));
  p_wrap_r8: assert property (@(posedge clk) disable iff (rst)
    (ph == 2'd3 && cond == 2'd0 && upc == {ADDR_W{1'b1}}) |=> (upc == '0));

endmodule

// File: tb/tb_useq_ctrl.sv
module tb_useq_ctrl;
  localparam int AW = 8;
  localparam int CW = 22;
  localparam int WW = CW + 2 + AW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [WW-1:0] wr_data = '0;
  logic flag_n = 1'b0, flag_z = 1'b0;
  logic [CW-1:0] ctrl_out;
  logic [AW-1:0] upc;
  logic [1:0] phase;

  int errors = 0, checks = 0, cycles = 0;
  bit done = 0;

  logic [WW-1:0] img [256];
  logic [AW-1:0] m_pc;
  logic [1:0] m_ph;
  logic [WW-1:0] m_mir;

  useq_ctrl #(.ADDR_W(AW), .CTRL_W(CW)) dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .flag_n(flag_n), .flag_z(flag_z), .ctrl_out(ctrl_out), .upc(upc), .phase(phase));

  always #2 clk = ~clk;

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      $display("FAIL watchdog: run hung, actual cycles=%0d expected <150000", cycles);
      errors = errors + 1;
      checks = checks + 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  // R1 layout: {target, cond, ctrl}
  function automatic logic [WW-1:0] mk(input logic [AW-1:0] t, input logic [1:0] c,
                                       input logic [CW-1:0] k);
    return {t, c, k};
  endfunction

  function automatic string tag(input logic [1:0] c);
    case (c)
      2'd0: return "R4";
      2'd1: return "R5";
      2'd2: return "R6";
      default: return "R7";
    endcase
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks = checks + 1;
    if (act !== exp) begin
      errors = errors + 1;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic load_and_reset();
    @(negedge clk);
    rst = 1'b1;
    for (int a = 0; a < 256; a++) begin
      wr_en = 1'b1;
      wr_addr = AW'(a);
      wr_data = img[a];
      @(negedge clk);
    end
    wr_en = 1'b0;
    rst = 1'b0;
    // R2: state after the last reset edge
    chk("R2 upc", 32'(upc), 0);
    chk("R2 phase", 32'(phase), 0);
    chk("R2 ctrl_out", 32'(ctrl_out), 0);
    m_pc = '0;
    m_ph = '0;
    m_mir = '0;
  endtask

  // R3 R9 R10 R11 R12: compare every cycle, drive flags, advance model
  task automatic run(input int ncyc);
    int mc = 0;
    for (int i = 0; i < ncyc; i++) begin
      logic n, z, take;
      if (i != 0) begin
        chk("R3 phase", 32'(phase), 32'(m_ph));
        chk(m_ph == 0 ? tag(m_mir[CW+:2]) : "R11", 32'(upc), 32'(m_pc));
        chk("R9 R12 ctrl_out", 32'(ctrl_out), 32'(m_mir[CW-1:0]));
      end
      n = mc[0] ^ mc[3];
      z = mc[1] ^ mc[2] ^ mc[4];
      if (m_ph == 2'd3) begin
        flag_n = n;
        flag_z = z;
      end else begin
        flag_n = ~n;  // R10: misleading values outside the deciding edge
        flag_z = ~z;
      end
      if (m_ph == 2'd0) m_mir = img[m_pc];
      if (m_ph == 2'd3) begin
        case (m_mir[CW+:2])
          2'd0: take = 1'b0;
          2'd1: take = n;
          2'd2: take = z;
          default: take = 1'b1;
        endcase
        m_pc = take ? m_mir[CW+2+:AW] : AW'((int'(m_pc) + 1) % 256);
        mc++;
      end
      m_ph = 2'((int'(m_ph) + 1) % 4);
      @(negedge clk);
    end
  endtask

  initial begin
    for (int a = 0; a < 256; a++)
      img[a] = mk(AW'((a * 73 + 29) % 256), 2'(a ^ (a >> 2)),
                  {AW'(a), ~AW'(a), 6'(a * 5)});
    load_and_reset();
    run(2000);

    // R8: 0 -> 254 by jump, then 254 -> 255 -> 0 sequentially
    for (int a = 0; a < 256; a++) img[a] = mk('0, 2'd0, CW'(a + 1));
    img[0] = mk(8'd254, 2'd3, 22'h3ABCDE);
    load_and_reset();
    run(13);
    chk("R8 wrap upc", 32'(upc), 0);
    run(400);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule